// File: doc/BRIEF.md
# DMA Channel Address Generator with Base Reload

This block produces the running source and destination addresses for one DMA channel. Each side has its own base address, access width, stepping mode and reload policy. A channel controller tells it when the channel starts and when a beat, a block or a whole transaction has completed. The block then moves each side's current address by the access size, holds it, or returns it to the base.

Base addresses are double-buffered. Software writes the base through a write strobe. While the channel is idle the new value becomes active at once. While the channel is busy it waits in a shadow register and becomes active when the transaction ends or when the channel goes idle. Byte counting, bus handshakes and data movement belong to other blocks.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset both current addresses and both active base addresses are 0x0000_0000.
- R2: On `start`, each side whose reload policy is TRANSACTION (code 0) or BLOCK (code 1) loads its current address from its active base. A base written in the same idle cycle is used.
- R3: On `beat_done` with no higher-priority event, INC mode (code 0) adds the step and DEC mode (code 1) subtracts it. The step is 1, 2 or 4 bytes for width code 0, 1 or 2/3.
- R4: In FIXED mode (code 2 or 3), `beat_done` leaves the current address unchanged.
- R5: Address arithmetic wraps modulo 2^32 in both directions and raises no error.
- R6: A side with BLOCK policy reloads its base on `blk_done`. A reload takes precedence over a step in the same cycle. The priority is start, then transaction end, then block end, then beat.
- R7: A side with TRANSACTION policy reloads its base on `trans_done` and ignores `blk_done`, which then acts only through any step in the same cycle.
- R8: A side with NEVER policy (code 2 or 3) keeps its running address across `trans_done` and `start`. It loads the base only once after reset, or after a new base has become active.
- R9: A base written while `chan_busy` is high does not change the active base. It becomes active on the next `trans_done`, or as soon as `chan_busy` is low.
- R10: Source and destination are independent. Each follows only its own width, mode, policy and base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_busy | input | 1 | Channel is running a transaction |
| start | input | 1 | Channel start strobe |
| beat_done | input | 1 | One data access completed |
| blk_done | input | 1 | One block completed |
| trans_done | input | 1 | Whole transaction completed |
| src_base_we | input | 1 | Source base write strobe |
| src_base_wdata | input | 32 | Source base write value |
| dst_base_we | input | 1 | Destination base write strobe |
| dst_base_wdata | input | 32 | Destination base write value |
| src_width | input | 2 | Source width: 0 byte, 1 half, 2/3 word |
| src_mode | input | 2 | Source mode: 0 INC, 1 DEC, 2/3 FIXED |
| src_reload | input | 2 | Source policy: 0 TRANSACTION, 1 BLOCK, 2/3 NEVER |
| dst_width | input | 2 | Destination width, same coding |
| dst_mode | input | 2 | Destination mode, same coding |
| dst_reload | input | 2 | Destination policy, same coding |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |

## Verification
The hardest case to reach from the ports is a shadowed base write that is still pending when a reload arrives. The active base cannot be read directly. The stimulus therefore writes a new source base while the channel is busy and then raises `blk_done` with the source on BLOCK policy. The address must return to the old base. A following `trans_done` must then load the new base. The NEVER policy is reached by running several transactions back to back, so that a missing "keep running" behaviour shows up as a jump back to the base.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  localparam int ADDR_W = 32;

  typedef enum logic [1:0] {
    RL_TRANS = 2'd0,
    RL_BLOCK = 2'd1,
    RL_NEVER = 2'd2
  } reload_e;

  // Step in bytes for a width code.
  function automatic logic [ADDR_W-1:0] step_of(input logic [1:0] wcode);
    case (wcode)
      2'd0:    step_of = ADDR_W'(1);
      2'd1:    step_of = ADDR_W'(2);
      default: step_of = ADDR_W'(4);
    endcase
  endfunction

  // Next address after one access, wrapping modulo 2^ADDR_W.
  function automatic logic [ADDR_W-1:0] advance(input logic [ADDR_W-1:0] cur,
                                                input logic [1:0] mode,
                                                input logic [1:0] wcode);
    case (mode)
      2'd0:    advance = cur + step_of(wcode);
      2'd1:    advance = cur - step_of(wcode);
      default: advance = cur;
    endcase
  endfunction

  function automatic logic is_never(input logic [1:0] rl);
    return rl[1];
  endfunction
endpackage

// File: rtl/dma_ag_base_buf.sv
module dma_ag_base_buf
  import dma_ag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy,
  input  logic          trans_done,
  input  logic          we,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_eff,
  output logic          commit_evt
);
  logic [AW-1:0] active_q, shadow_q;
  logic          pend_q;
  logic          direct_wr, pend_commit;

  assign direct_wr   = we && !busy;
  assign pend_commit = pend_q && (trans_done || !busy) && !direct_wr;
  assign commit_evt  = direct_wr || pend_commit;
  assign base_eff    = direct_wr ? wdata : (pend_commit ? shadow_q : active_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= base_eff;
      if (we && busy) begin
        shadow_q <= wdata;
        pend_q   <= 1'b1;
      end else if (commit_evt) begin
        pend_q   <= 1'b0;
      end
    end
  end

  AST_BUSY_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy && !pend_q) |=> (active_q == $past(active_q))); // R9
  AST_COMMIT_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && trans_done && !direct_wr) |=> (active_q == $past(shadow_q))); // R9
endmodule

// File: rtl/dma_ag_side.sv
module dma_ag_side
  import dma_ag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          beat_done,
  input  logic          blk_done,
  input  logic          trans_done,
  input  logic [1:0]    width,
  input  logic [1:0]    mode,
  input  logic [1:0]    reload,
  input  logic [AW-1:0] base_eff,
  input  logic          commit_evt,
  output logic [AW-1:0] cur_addr
);
  logic [AW-1:0] cur_q;
  logic          fresh_q, fresh_now;
  logic          load_evt, step_evt;
  logic          end_load;

  assign fresh_now = fresh_q || commit_evt;
  assign end_load  = !is_never(reload) || fresh_now;

  always_comb begin
    if (start)           load_evt = end_load;
    else if (trans_done) load_evt = end_load;
    else if (blk_done)   load_evt = (reload == RL_BLOCK);
    else                 load_evt = 1'b0;
  end
  assign step_evt = beat_done && !load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      fresh_q <= 1'b1;
    end else begin
      if (load_evt)      cur_q <= base_eff;
      else if (step_evt) cur_q <= advance(cur_q, mode, width);
      fresh_q <= fresh_now && !load_evt;
    end
  end

  assign cur_addr = cur_q;

  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !is_never(reload)) |=> (cur_q == $past(base_eff))); // R2
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !start && !trans_done && !blk_done && mode == 2'd0)
      |=> (cur_q - $past(cur_q) == $past(step_of(width)))); // R3
  AST_FIXED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && !start && !trans_done && !blk_done && mode[1]) |=> $stable(cur_q)); // R4
  AST_BLOCK_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && reload == RL_BLOCK && !start && !trans_done)
      |=> (cur_q == $past(base_eff))); // R6
  AST_TRANS_IGNORES_BLK: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_done && reload == RL_TRANS && !beat_done && !start && !trans_done)
      |=> $stable(cur_q)); // R7
  AST_NEVER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (trans_done && is_never(reload) && !fresh_q && !commit_evt && !beat_done)
      |=> $stable(cur_q)); // R8
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_busy,
  input  logic          start,
  input  logic          beat_done,
  input  logic          blk_done,
  input  logic          trans_done,
  input  logic          src_base_we,
  input  logic [AW-1:0] src_base_wdata,
  input  logic          dst_base_we,
  input  logic [AW-1:0] dst_base_wdata,
  input  logic [1:0]    src_width,
  input  logic [1:0]    src_mode,
  input  logic [1:0]    src_reload,
  input  logic [1:0]    dst_width,
  input  logic [1:0]    dst_mode,
  input  logic [1:0]    dst_reload,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  localparam int SIDES = 2;

  logic          we_a     [SIDES];
  logic [AW-1:0] wdata_a  [SIDES];
  logic [1:0]    width_a  [SIDES];
  logic [1:0]    mode_a   [SIDES];
  logic [1:0]    reload_a [SIDES];
  logic [AW-1:0] base_a   [SIDES];
  logic          commit_a [SIDES];
  logic [AW-1:0] cur_a    [SIDES];

  assign we_a[0] = src_base_we;      assign we_a[1] = dst_base_we;
  assign wdata_a[0] = src_base_wdata; assign wdata_a[1] = dst_base_wdata;
  assign width_a[0] = src_width;     assign width_a[1] = dst_width;
  assign mode_a[0] = src_mode;       assign mode_a[1] = dst_mode;
  assign reload_a[0] = src_reload;   assign reload_a[1] = dst_reload;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    dma_ag_base_buf #(.AW(AW)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy       (chan_busy),
      .trans_done (trans_done),
      .we         (we_a[s]),
      .wdata      (wdata_a[s]),
      .base_eff   (base_a[s]),
      .commit_evt (commit_a[s])
    );
    dma_ag_side #(.AW(AW)) u_side (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .beat_done  (beat_done),
      .blk_done   (blk_done),
      .trans_done (trans_done),
      .width      (width_a[s]),
      .mode       (mode_a[s]),
      .reload     (reload_a[s]),
      .base_eff   (base_a[s]),
      .commit_evt (commit_a[s]),
      .cur_addr   (cur_a[s])
    );
  end

  assign src_addr = cur_a[0];
  assign dst_addr = cur_a[1];

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (src_addr == '0 && dst_addr == '0)); // R1
  AST_SIDES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !trans_done && !blk_done && beat_done && src_mode[1] && !dst_mode[1])
      |=> ($stable(src_addr) && !$stable(dst_addr))); // R10
endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic chan_busy = 0, start = 0, beat_done = 0, blk_done = 0, trans_done = 0;
  logic src_base_we = 0, dst_base_we = 0;
  logic [31:0] src_base_wdata = 0, dst_base_wdata = 0;
  logic [1:0] src_width = 2, src_mode = 0, src_reload = 0;
  logic [1:0] dst_width = 1, dst_mode = 1, dst_reload = 1;
  logic [31:0] src_addr, dst_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_gen u_dut (.*);

  // independent reference state, per side (0 = source, 1 = destination)
  logic [31:0] r_cur[2], r_act[2], r_sh[2];
  logic        r_pend[2], r_new[2];

  logic [31:0] q_src[$], q_dst[$];
  string       q_tag[$];
  int checks = 0, failures = 0;
  bit done = 0;

  always @(negedge clk) begin
    while (q_src.size() > 0) begin
      logic [31:0] es, ed;
      string t;
      es = q_src.pop_front(); ed = q_dst.pop_front(); t = q_tag.pop_front();
      checks++;
      if (src_addr !== es || dst_addr !== ed) begin
        failures++;
        $display("FAIL %s: src=%h dst=%h expected src=%h dst=%h", t, src_addr, dst_addr, es, ed);
      end
    end
  end

  function automatic logic [31:0] bytes_for(input logic [1:0] w);
    return (w == 0) ? 32'd1 : (w == 1) ? 32'd2 : 32'd4;
  endfunction

  task automatic predict(input int s, input logic we, input logic [31:0] wd,
                         input logic [1:0] w, input logic [1:0] m, input logic [1:0] rl);
    logic idle_wr, late, nev, ld;
    logic [31:0] nb;
    idle_wr = we && !chan_busy;
    late    = r_pend[s] && !idle_wr && (trans_done || !chan_busy);
    nb      = idle_wr ? wd : late ? r_sh[s] : r_act[s];
    nev     = (rl >= 2);
    if (idle_wr || late) r_new[s] = 1;
    ld = 0;
    if (start || trans_done) ld = !nev || r_new[s];
    else if (blk_done)       ld = (rl == 1);
    if (ld) begin
      r_cur[s] = nb;
      r_new[s] = 0;
    end else if (beat_done) begin
      if (m == 0)      r_cur[s] = r_cur[s] + bytes_for(w);
      else if (m == 1) r_cur[s] = r_cur[s] - bytes_for(w);
    end
    r_act[s] = nb;
    if (we && chan_busy) begin r_sh[s] = wd; r_pend[s] = 1; end
    else if (idle_wr || late) r_pend[s] = 0;
  endtask

  // one clock of stimulus; expected result is queued for the monitor
  task automatic cyc(input bit st, input bit bt, input bit bk, input bit tr,
                     input bit swe, input logic [31:0] swd,
                     input bit dwe, input logic [31:0] dwd, input string tag);
    start = st; beat_done = bt; blk_done = bk; trans_done = tr;
    src_base_we = swe; src_base_wdata = swd; dst_base_we = dwe; dst_base_wdata = dwd;
    predict(0, swe, swd, src_width, src_mode, src_reload);
    predict(1, dwe, dwd, dst_width, dst_mode, dst_reload);
    @(posedge clk);
    q_src.push_back(r_cur[0]); q_dst.push_back(r_cur[1]); q_tag.push_back(tag);
    @(negedge clk);
    start = 0; beat_done = 0; blk_done = 0; trans_done = 0;
    src_base_we = 0; dst_base_we = 0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < 2; s++) begin
      r_cur[s] = 0; r_act[s] = 0; r_sh[s] = 0; r_pend[s] = 0; r_new[s] = 1;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc(0,0,0,0, 0,0, 0,0, "R1 reset state");

    // src word INC TRANSACTION, dst half DEC BLOCK
    cyc(0,0,0,0, 1,32'h1000, 1,32'h2000, "R2 idle write does not move address");
    cyc(1,0,0,0, 0,0, 0,0, "R2 start loads base");
    chan_busy = 1;
    for (int i = 0; i < 3; i++) cyc(0,1,0,0, 0,0, 0,0, "R3 inc/dec step");
    cyc(0,1,1,0, 0,0, 0,0, "R6 block reload beats step, R7 trans side ignores block");
    cyc(0,1,0,0, 1,32'h5000, 0,0, "R9 busy write held");
    cyc(0,0,1,0, 0,0, 0,0, "R7 blk_done no reload for trans policy");
    cyc(0,1,0,1, 0,0, 0,0, "R9 shadow commits at trans_done, R7 reload");

    dst_mode = 2;
    cyc(0,1,0,0, 0,0, 0,0, "R4 fixed holds");
    cyc(0,1,0,0, 0,0, 0,0, "R4 fixed holds again");

    // R9: pending base not used by a block reload before the end
    src_reload = 1; dst_mode = 0;
    cyc(0,1,0,0, 1,32'h9000, 0,0, "R9 second busy write");
    cyc(0,0,1,0, 0,0, 0,0, "R9 block reload uses old base");
    chan_busy = 0;
    cyc(0,0,0,0, 0,0, 0,0, "R9 commit on idle");
    cyc(0,0,1,0, 0,0, 0,0, "R9 block reload uses committed base");

    // wrap
    src_reload = 0; src_mode = 0; src_width = 2;
    dst_reload = 0; dst_mode = 1; dst_width = 1;
    cyc(1,0,0,0, 1,32'hFFFF_FFFE, 1,32'h0000_0001, "R2 start with same-cycle write");
    chan_busy = 1;
    cyc(0,1,0,0, 0,0, 0,0, "R5 wrap both directions");
    src_width = 0; dst_width = 3;
    cyc(0,1,0,0, 0,0, 0,0, "R3 byte and word step");

    // NEVER policy
    src_reload = 2; dst_reload = 3; src_mode = 0; dst_mode = 0; src_width = 1; dst_width = 0;
    cyc(0,1,0,1, 0,0, 0,0, "R8 trans_done keeps running address");
    chan_busy = 0;
    cyc(1,0,0,0, 0,0, 0,0, "R8 start keeps running address");
    chan_busy = 1;
    cyc(0,1,0,0, 0,0, 0,0, "R8 continues stepping");
    chan_busy = 0;
    cyc(0,0,0,0, 1,32'h7000, 0,0, "R8 idle write no jump yet");
    cyc(1,1,0,0, 0,0, 0,0, "R8 start loads new base on source only");

    // independence
    chan_busy = 1; src_reload = 1; dst_reload = 2; dst_mode = 2; src_mode = 1; src_width = 2;
    cyc(0,1,0,0, 0,0, 0,0, "R10 src steps, dst fixed");
    cyc(0,1,1,0, 0,0, 0,0, "R10 src block reload, dst untouched");
    dst_mode = 0; src_mode = 2;
    cyc(0,1,0,0, 0,0, 0,0, "R10 dst steps, src fixed");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule